// File: doc/BRIEF.md
# Wait-Mode Clock Gating Sequencer

This block brings a microcontroller into a low-power wait state and out of it again. When the core raises a wait request, the block captures six per-domain wait configuration bits. It then works through a fixed shutdown order, one step per cycle of the always-running reference clock. First it moves the system and core clocks off the PLL by clearing the PLL-select flag. Next it stops the PLL, then the core clocks, then the remaining system clocks. Only after those steps does it raise the wait-active status. The configuration bits can be combined freely, and each one affects only its own domain. The real-time-interrupt clock, the watchdog clock and an oscillator amplitude-reduce request are handled in the same step as the system clocks.

A wake event received while in wait mode brings the domains back in reverse order: system clocks first, then core clocks, then the PLL. Wait-active clears in the same cycle that the PLL comes back. The PLL-select flag is left cleared after wake-up, and software must set it again through the write port once the PLL is usable. The real-time-interrupt and watchdog clock enables are also held low at all times while their rate-select fields are zero. There is no data stream, so every pin is a plain level or strobe. Clock enables are level signals that a separate glitch-free gating stage consumes.

Top module: `wm_clk_gate_seq`

## Requirements
- R1: After reset, pll_sel=0, wait_active=0, osc_amp_low=0, pll_en=core_clk_en=sys_clk_en=1, and rti_clk_en/cop_clk_en are 1 whenever their rate field is nonzero.
- R2: The six configuration inputs are captured at the clock edge where wait_req is sampled high in the run state. Changing them afterwards has no effect on the sequence or on wait mode.
- R3: With the PLL-wait bit captured, pll_sel goes to 0 one edge after capture and pll_en goes to 0 one edge later. pll_sel is therefore already 0 whenever pll_en falls.
- R4: With core-wait captured, core_clk_en goes to 0 at the third edge after capture. With system-wait captured, sys_clk_en goes to 0 at the fourth.
- R5: wait_active goes to 1 at the fifth edge after capture (the sixth counted from the request edge), after every selected domain is off. It stays 1 until a wake.
- R6: Each configuration bit stops only its own domain. Any combination of the six bits gives the union of their individual effects.
- R7: With RTI-wait or COP-wait captured, rti_clk_en or cop_clk_en respectively goes to 0 in the same step as the system clocks. It is restored at the first wake step.
- R8: With the amplitude-reduce bit captured, osc_amp_low goes to 1 in the system-clock step. It returns to 0 at the first wake step.
- R9: rti_clk_en is 0 whenever rti_rate is all zero, and cop_clk_en is 0 whenever cop_rate is all zero, in any state.
- R10: A wake in wait mode restores sys_clk_en at the first edge and core_clk_en at the second. It restores pll_en and clears wait_active at the third, which returns the block to run.
- R11: pll_sel stays 0 after wake-up. A pll_sel_wr strobe loads pll_sel_wdata only in the run state and is ignored in every other state.
- R12: wait_req outside the run state and wake_evt outside wait mode are ignored.
- R13: A request with no configuration bit set still asserts wait_active at the same edge, and leaves every clock enable and pll_sel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Core request to enter wait mode |
| wake_evt | input | 1 | Wake event (interrupt or reset request) |
| cfg_pll_wait | input | 1 | Stop PLL in wait |
| cfg_core_wait | input | 1 | Stop core clocks in wait |
| cfg_sys_wait | input | 1 | Stop remaining system clocks in wait |
| cfg_rti_wait | input | 1 | Stop real-time-interrupt clock in wait |
| cfg_cop_wait | input | 1 | Stop watchdog clock in wait |
| cfg_amp_wait | input | 1 | Request reduced oscillator amplitude in wait |
| pll_sel_wr | input | 1 | Software write strobe for pll_sel |
| pll_sel_wdata | input | 1 | Value written to pll_sel |
| rti_rate | input | RTI_RATE_W | RTI rate select; all zero stops RTI clock |
| cop_rate | input | COP_RATE_W | Watchdog rate select; all zero stops watchdog clock |
| pll_sel | output | 1 | 1: system/core clocks from PLL, 0: from oscillator |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| rti_clk_en | output | 1 | Real-time-interrupt clock enable |
| cop_clk_en | output | 1 | Watchdog clock enable |
| osc_amp_low | output | 1 | Reduced oscillator amplitude request |
| wait_active | output | 1 | Wait mode fully entered |

## Verification
The shutdown and wake sequences run for all 64 combinations of the configuration bits. Each step's output vector is compared with the value computed from the set bits and the step index. This separates a wrong order, a wrong cycle, a domain that leaks into another, and a missing union of effects. Every combination also inverts the configuration inputs right after capture, so a design that reads them live instead of latching them gives different results. Separate patterns cover zero rate fields, pll_sel writes and wake events outside the run state, and a repeated request or early wake during the sequence. These show whether the block ignores stimulus that arrives in the wrong state.

// File: rtl/wm_pkg.sv
package wm_pkg;

  typedef enum logic [3:0] {
    ST_RUN      = 4'd0,
    ST_CAPTURE  = 4'd1,
    ST_SEL_OFF  = 4'd2,
    ST_PLL_OFF  = 4'd3,
    ST_CORE_OFF = 4'd4,
    ST_SYS_OFF  = 4'd5,
    ST_WAIT     = 4'd6,
    ST_SYS_ON   = 4'd7,
    ST_CORE_ON  = 4'd8
  } wm_state_e;

  typedef struct packed {
    logic pll;
    logic core;
    logic sys;
    logic rti;
    logic cop;
    logic amp;
  } wm_cfg_t;

  typedef struct packed {
    logic sel_off;
    logic pll_off;
    logic core_off;
    logic sys_off;
    logic enter_wait;
    logic sys_on;
    logic core_on;
    logic pll_on;
  } wm_act_t;

endpackage

// File: rtl/wm_cfg_capture.sv
module wm_cfg_capture
  import wm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    capture,
  input  wm_cfg_t cfg_in,
  output wm_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (capture) begin
      cfg_q <= cfg_in;
    end
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cfg_q)) else $error("cfg changed without capture"); // R2

endmodule

// File: rtl/wm_seq_fsm.sv
module wm_seq_fsm
  import wm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_req,
  input  logic      wake_evt,
  output wm_state_e state,
  output logic      capture,
  output wm_act_t   act
);

  wm_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_RUN:      if (wait_req) state_nxt = ST_CAPTURE;
      ST_CAPTURE:  state_nxt = ST_SEL_OFF;
      ST_SEL_OFF:  state_nxt = ST_PLL_OFF;
      ST_PLL_OFF:  state_nxt = ST_CORE_OFF;
      ST_CORE_OFF: state_nxt = ST_SYS_OFF;
      ST_SYS_OFF:  state_nxt = ST_WAIT;
      ST_WAIT:     if (wake_evt) state_nxt = ST_SYS_ON;
      ST_SYS_ON:   state_nxt = ST_CORE_ON;
      ST_CORE_ON:  state_nxt = ST_RUN;
      default:     state_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
    end else begin
      state <= state_nxt;
    end
  end

  // Actions applied by the gate bank at the coming edge.
  always_comb begin
    act            = '0;
    act.sel_off    = (state == ST_CAPTURE);
    act.pll_off    = (state == ST_SEL_OFF);
    act.core_off   = (state == ST_PLL_OFF);
    act.sys_off    = (state == ST_CORE_OFF);
    act.enter_wait = (state == ST_SYS_OFF);
    act.sys_on     = (state == ST_WAIT) && wake_evt;
    act.core_on    = (state == ST_SYS_ON);
    act.pll_on     = (state == ST_CORE_ON);
  end

  assign capture = (state == ST_RUN) && wait_req;

  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act)) else $error("several actions at once"); // R6
  AST_WAKE_ONLY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WAIT && state != ST_RUN && wake_evt) |=> state != ST_SYS_ON || $past(state) == ST_WAIT)
    else $error("wake accepted outside wait"); // R12

endmodule

// File: rtl/wm_gate_bank.sv
module wm_gate_bank
  import wm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wm_act_t act,
  input  wm_cfg_t cfg_q,
  input  logic    sw_wr_ok,
  input  logic    sw_wdata,
  output logic    pll_sel,
  output logic    pll_en,
  output logic    core_en,
  output logic    sys_en,
  output logic    rti_stop,
  output logic    cop_stop,
  output logic    amp_low,
  output logic    wait_active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_sel <= 1'b0;
    end else if (act.sel_off && cfg_q.pll) begin
      pll_sel <= 1'b0;
    end else if (sw_wr_ok) begin
      pll_sel <= sw_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_en <= 1'b1;
    end else if (act.pll_off && cfg_q.pll) begin
      pll_en <= 1'b0;
    end else if (act.pll_on) begin
      pll_en <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en <= 1'b1;
    end else if (act.core_off && cfg_q.core) begin
      core_en <= 1'b0;
    end else if (act.core_on) begin
      core_en <= 1'b1;
    end
  end

  // System step: system clocks, RTI, watchdog and amplitude request together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_en   <= 1'b1;
      rti_stop <= 1'b0;
      cop_stop <= 1'b0;
      amp_low  <= 1'b0;
    end else if (act.sys_off) begin
      sys_en   <= ~cfg_q.sys;
      rti_stop <= cfg_q.rti;
      cop_stop <= cfg_q.cop;
      amp_low  <= cfg_q.amp;
    end else if (act.sys_on) begin
      sys_en   <= 1'b1;
      rti_stop <= 1'b0;
      cop_stop <= 1'b0;
      amp_low  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_active <= 1'b0;
    end else if (act.enter_wait) begin
      wait_active <= 1'b1;
    end else if (act.pll_on) begin
      wait_active <= 1'b0;
    end
  end

  AST_SEL_BEFORE_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> !pll_sel) else $error("PLL stopped while selected"); // R3
  AST_CORE_AFTER_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> sys_en) else $error("core back before system"); // R10
  AST_PLL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> (core_en && sys_en)) else $error("PLL back too early"); // R10
  AST_WAIT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_active) |-> ((!cfg_q.pll || !pll_en) && (!cfg_q.core || !core_en)
                             && (!cfg_q.sys || !sys_en))) else $error("wait before off"); // R5

endmodule

// File: rtl/wm_rate_gate.sv
module wm_rate_gate #(
  parameter int W = 4
) (
  input  logic [W-1:0] rate,
  input  logic         stop,
  output logic         en
);

  logic rate_live;

  assign rate_live = |rate;
  assign en        = rate_live && !stop;

endmodule

// File: rtl/wm_clk_gate_seq.sv
module wm_clk_gate_seq
  import wm_pkg::*;
#(
  parameter int RTI_RATE_W = 4,
  parameter int COP_RATE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wait_req,
  input  logic                  wake_evt,
  input  logic                  cfg_pll_wait,
  input  logic                  cfg_core_wait,
  input  logic                  cfg_sys_wait,
  input  logic                  cfg_rti_wait,
  input  logic                  cfg_cop_wait,
  input  logic                  cfg_amp_wait,
  input  logic                  pll_sel_wr,
  input  logic                  pll_sel_wdata,
  input  logic [RTI_RATE_W-1:0] rti_rate,
  input  logic [COP_RATE_W-1:0] cop_rate,
  output logic                  pll_sel,
  output logic                  pll_en,
  output logic                  core_clk_en,
  output logic                  sys_clk_en,
  output logic                  rti_clk_en,
  output logic                  cop_clk_en,
  output logic                  osc_amp_low,
  output logic                  wait_active
);

  wm_state_e state;
  wm_act_t   act;
  wm_cfg_t   cfg_in;
  wm_cfg_t   cfg_q;
  logic      capture;
  logic      rti_stop;
  logic      cop_stop;
  logic      sw_wr_ok;

  assign cfg_in = '{pll:  cfg_pll_wait,  core: cfg_core_wait, sys: cfg_sys_wait,
                    rti:  cfg_rti_wait,  cop:  cfg_cop_wait,  amp: cfg_amp_wait};

  assign sw_wr_ok = pll_sel_wr && (state == ST_RUN);

  wm_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_req (wait_req),
    .wake_evt (wake_evt),
    .state    (state),
    .capture  (capture),
    .act      (act)
  );

  wm_cfg_capture u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q)
  );

  wm_gate_bank u_gates (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .cfg_q       (cfg_q),
    .sw_wr_ok    (sw_wr_ok),
    .sw_wdata    (pll_sel_wdata),
    .pll_sel     (pll_sel),
    .pll_en      (pll_en),
    .core_en     (core_clk_en),
    .sys_en      (sys_clk_en),
    .rti_stop    (rti_stop),
    .cop_stop    (cop_stop),
    .amp_low     (osc_amp_low),
    .wait_active (wait_active)
  );

  wm_rate_gate #(.W(RTI_RATE_W)) u_rti_gate (
    .rate (rti_rate),
    .stop (rti_stop),
    .en   (rti_clk_en)
  );

  wm_rate_gate #(.W(COP_RATE_W)) u_cop_gate (
    .rate (cop_rate),
    .stop (cop_stop),
    .en   (cop_clk_en)
  );

  AST_PLLSEL_RISE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel) |-> $past(state) == ST_RUN) else $error("pll_sel set outside run"); // R11
  AST_AMP_ONLY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    osc_amp_low |-> (state == ST_SYS_OFF || state == ST_WAIT)) else $error("amp low outside wait"); // R8
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && wait_req) |=> $stable(cfg_q)) else $error("request re-captured"); // R12

endmodule

// File: tb/wm_clk_gate_seq_tb.sv
module wm_clk_gate_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 1'b0, wake_evt = 1'b0;
  logic [5:0] cfg = '0;   // [0]pll [1]core [2]sys [3]rti [4]cop [5]amp
  logic pll_sel_wr = 1'b0, pll_sel_wdata = 1'b0;
  logic [3:0] rti_rate = 4'd5;
  logic [2:0] cop_rate = 3'd3;
  logic pll_sel, pll_en, core_clk_en, sys_clk_en, rti_clk_en, cop_clk_en, osc_amp_low, wait_active;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wm_clk_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wake_evt(wake_evt),
    .cfg_pll_wait(cfg[0]), .cfg_core_wait(cfg[1]), .cfg_sys_wait(cfg[2]),
    .cfg_rti_wait(cfg[3]), .cfg_cop_wait(cfg[4]), .cfg_amp_wait(cfg[5]),
    .pll_sel_wr(pll_sel_wr), .pll_sel_wdata(pll_sel_wdata),
    .rti_rate(rti_rate), .cop_rate(cop_rate),
    .pll_sel(pll_sel), .pll_en(pll_en), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .rti_clk_en(rti_clk_en), .cop_clk_en(cop_clk_en), .osc_amp_low(osc_amp_low),
    .wait_active(wait_active)
  );

  function automatic logic [7:0] outv();
    return {pll_sel, pll_en, core_clk_en, sys_clk_en, rti_clk_en, cop_clk_en, osc_amp_low, wait_active};
  endfunction

  // k = edges since the request edge (k=1 right after capture)
  function automatic logic [7:0] exp_enter(int c, int k, bit psel0);
    logic [7:0] e;
    e[7] = psel0 && !(c[0] && k >= 2);
    e[6] = !(c[0] && k >= 3);
    e[5] = !(c[1] && k >= 4);
    e[4] = !(c[2] && k >= 5);
    e[3] = !(c[3] && k >= 5);
    e[2] = !(c[4] && k >= 5);
    e[1] = c[5] && k >= 5;
    e[0] = k >= 6;
    return e;
  endfunction

  // w = edges since the wake edge
  function automatic logic [7:0] exp_wake(int c, int w, bit psel0);
    logic [7:0] e;
    e[7] = psel0 && !c[0];
    e[6] = !c[0] || w >= 3;
    e[5] = !c[1] || w >= 2;
    e[4] = 1'b1;
    e[3] = 1'b1;
    e[2] = 1'b1;
    e[1] = 1'b0;
    e[0] = w < 3;
    return e;
  endfunction

  function automatic string tag_enter(int c, int k);
    if (c == 0) return "R13";
    case (k)
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return (c[3] || c[4]) ? "R7" : (c[5] ? "R8" : "R4");
      default: return (k == 6) ? "R5" : "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sw_write(bit v);
    @(negedge clk); pll_sel_wr = 1'b1; pll_sel_wdata = v;
    @(negedge clk); pll_sel_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", outv(), 8'b0111_1100);

    // R12: wake in run has no effect
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    @(negedge clk);
    check("R12", outv(), 8'b0111_1100);

    // R9: zero rate fields stop RTI/watchdog clocks
    rti_rate = '0; #1;
    check("R9", {7'b0, rti_clk_en}, 8'd0);
    cop_rate = '0; #1;
    check("R9", {7'b0, cop_clk_en}, 8'd0);
    rti_rate = 4'd5; cop_rate = 3'd3; #1;
    check("R9", {6'b0, rti_clk_en, cop_clk_en}, 8'd3);

    // Exhaustive sweep of all configuration combinations
    for (int c = 0; c < 64; c++) begin
      bit psel0;
      psel0 = c[1];  // alternate starting pll_sel
      sw_write(psel0);
      @(negedge clk);
      check("R11", {7'b0, pll_sel}, {7'b0, psel0});
      cfg = c[5:0]; wait_req = 1'b1;
      @(negedge clk);
      wait_req = 1'b0;
      check(tag_enter(c, 1), outv(), exp_enter(c, 1, psel0));
      cfg = ~c[5:0];  // R2: must not matter after capture
      for (int k = 2; k <= 7; k++) begin
        @(negedge clk);
        check(tag_enter(c, k), outv(), exp_enter(c, k, psel0));
      end
      wake_evt = 1'b1;
      for (int w = 1; w <= 3; w++) begin
        @(negedge clk);
        wake_evt = 1'b0;
        check((w == 3) ? "R11" : "R10", outv(), exp_wake(c, w, psel0));
      end
      @(negedge clk);
      check("R11", {7'b0, pll_sel}, {7'b0, psel0 && !c[0]});
    end

    // R12: early wake and repeated request during sequence, write during wait
    sw_write(1'b1);
    cfg = 6'h3F; wait_req = 1'b1;
    @(negedge clk); wait_req = 1'b0; cfg = 6'h00;
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    for (int k = 4; k <= 6; k++) @(negedge clk);
    check("R12", outv(), exp_enter(63, 6, 1'b1));
    wait_req = 1'b1; pll_sel_wr = 1'b1; pll_sel_wdata = 1'b1;
    @(negedge clk); wait_req = 1'b0; pll_sel_wr = 1'b0;
    @(negedge clk);
    check("R12", outv(), exp_enter(63, 6, 1'b1));
    check("R11", {7'b0, pll_sel}, 8'd0);
    wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10", outv(), exp_wake(63, 3, 1'b1));
    @(negedge clk);
    check("R12", outv(), 8'b0111_1100);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule